// File: doc/BRIEF.md
# Bridge-Steered PWM Generator

This block produces one pulse-width-modulated waveform with 10-bit resolution and routes it to up to four output lines. The lines can drive a single load, the two switches of a half bridge, or the four switches of a full bridge in either direction. The time base is an 8-bit period timer extended downward by a free-running 2-bit sub-count. One period therefore lasts four clocks for every timer step. The duty comparison always uses a shadow copy of the duty value. That copy, the period limit and the steering mode are refreshed only at a period boundary, so software may rewrite them at any time without producing a runt pulse.

Software programs the block through a simple write port with three registers. Address 0 holds the 8-bit period limit P. Address 1 holds the upper 8 bits of the duty value. Address 2 is the control word: bits [1:0] are the two duty LSBs, bits [3:2] select the steering, bits [7:6] are the run key, and bits [5:4] are spare. The full duty value is D = {address 1, control[1:0]}. The steering codes are 00 single, 10 half bridge, 01 full bridge forward and 11 full bridge reverse. Output bit 0 is line A, bit 1 is B, bit 2 is C and bit 3 is D. All outputs are active high.

Top module: `bridge_pwm`

## Requirements
- R1: After reset all four outputs are low and the generator is stopped.
- R2: The generator runs only while control bits [7:6] equal 11. With any other key, all outputs are low. Writing 0x00 to the control word drives every output low by the second clock after the write.
- R3: One PWM period lasts (P+1)*4 clocks, where P is the period register value (0 to 255).
- R4: The modulated waveform is high for min(D, (P+1)*4) clocks of each period, with D = {duty register, control[1:0]}. D = 0 keeps it low for the whole period.
- R5: Steering 00 (single) puts the waveform on A and holds B, C and D low.
- R6: Steering 10 (half bridge) puts the waveform on A and its complement on B, and holds C and D low.
- R7: Steering 01 (full forward) holds A high, puts the waveform on D, and holds B and C low.
- R8: Steering 11 (full reverse) holds C high, puts the waveform on B, and holds A and D low.
- R9: A duty value written during a period is used only from the next period boundary. The pulse in progress keeps its old width.
- R10: A period or steering value written during a period takes effect only at the next period boundary. The period in progress keeps its length, and a newly selected output does not switch before that boundary.
- R11: A write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 duty high, 2 control |
| wr_data | input | 8 | Write data |
| pwm_out | output | 4 | Steered outputs: bit 0 A, bit 1 B, bit 2 C, bit 3 D |

## Verification
Every steering code is driven with duty values of zero, an odd mid-scale value, an even mid-scale value and a value above the period length. Counting the high clocks on each line over one full period separates the modulated line from the held-high, held-low and complementary lines in each mode. The zero and oversized duty values show the saturation at both ends, and the odd value exposes any loss of the two duty LSBs. Writes placed in the middle of a pulse show whether the duty, period and steering shadows wait for the boundary. Non-running keys and a cleared control word confirm that the outputs go quiet.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;

   typedef enum logic [1:0] {
      STEER_SINGLE = 2'b00,
      STEER_FWD    = 2'b01,
      STEER_HALF   = 2'b10,
      STEER_REV    = 2'b11
   } steer_e;

   // per-output role inside a steering pattern
   typedef enum logic [1:0] {
      ROLE_LOW  = 2'b00,
      ROLE_MOD  = 2'b01,
      ROLE_INV  = 2'b10,
      ROLE_HIGH = 2'b11
   } role_e;

   localparam logic [1:0] ADDR_PERIOD = 2'd0;
   localparam logic [1:0] ADDR_DUTY   = 2'd1;
   localparam logic [1:0] ADDR_CTRL   = 2'd2;
   localparam logic [1:0] RUN_KEY     = 2'b11;

endpackage

// File: rtl/bpwm_timebase.sv
module bpwm_timebase #(
   parameter int TMR_W = 8,
   parameter int SUB_W = 2,
   localparam int CNT_W = TMR_W + SUB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [TMR_W-1:0] per_in,
   output logic [CNT_W-1:0] cnt,
   output logic             boundary
);

   logic [TMR_W-1:0] tmr_q;
   logic [TMR_W-1:0] per_act_q;
   logic [SUB_W-1:0] sub_q;
   logic             wrap;

   if (TMR_W < 2 || SUB_W < 1) begin : g_bad_width
      $error("bpwm_timebase: TMR_W must be >= 2 and SUB_W >= 1");
   end

   assign wrap     = run && (tmr_q == per_act_q) && (&sub_q);
   assign boundary = !run || wrap;
   assign cnt      = {tmr_q, sub_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q     <= '0;
         sub_q     <= '0;
         per_act_q <= '0;
      end else if (boundary) begin
         tmr_q     <= '0;
         sub_q     <= '0;
         per_act_q <= per_in;
      end else begin
         {tmr_q, sub_q} <= {tmr_q, sub_q} + 1'b1;
      end
   end

   assert_tmr_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (tmr_q <= per_act_q));

   assert_wrap_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));

   assert_period_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(per_act_q));

endmodule

// File: rtl/bpwm_duty.sv
module bpwm_duty #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] duty_in,
   input  logic [CNT_W-1:0] cnt,
   output logic             level
);

   logic [CNT_W-1:0] duty_q;

   if (CNT_W < 3) begin : g_bad_width
      $error("bpwm_duty: CNT_W must be >= 3");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     duty_q <= '0;
      else if (load)  duty_q <= duty_in;
   end

   // high from the period start until the count reaches the shadow duty
   assign level = (cnt < duty_q);

   assert_duty_shadow_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(duty_q));

   assert_zero_duty_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_q == '0) |-> !level);

endmodule

// File: rtl/bpwm_steer.sv
module bpwm_steer
   import bpwm_pkg::*;
#(
   parameter int N_OUT = 4
) (
   input  steer_e           mode,
   input  logic             level,
   output logic [N_OUT-1:0] drive
);

   if (N_OUT != 4) begin : g_bad_count
      $error("bpwm_steer: bridge steering needs exactly four outputs");
   end

   function automatic role_e role_of(steer_e m, int idx);
      role_e r;
      r = ROLE_LOW;
      unique case (m)
         STEER_SINGLE: if (idx == 0) r = ROLE_MOD;
         STEER_HALF: begin
            if (idx == 0) r = ROLE_MOD;
            if (idx == 1) r = ROLE_INV;
         end
         STEER_FWD: begin
            if (idx == 0) r = ROLE_HIGH;
            if (idx == 3) r = ROLE_MOD;
         end
         STEER_REV: begin
            if (idx == 2) r = ROLE_HIGH;
            if (idx == 1) r = ROLE_MOD;
         end
         default: r = ROLE_LOW;
      endcase
      return r;
   endfunction

   for (genvar i = 0; i < N_OUT; i++) begin : g_line
      always_comb begin
         unique case (role_of(mode, i))
            ROLE_MOD:  drive[i] = level;
            ROLE_INV:  drive[i] = !level;
            ROLE_HIGH: drive[i] = 1'b1;
            default:   drive[i] = 1'b0;
         endcase
      end
   end

   always_comb begin
      if (mode == STEER_HALF)
         assert_half_opposed_R6: assert (drive[0] != drive[1]);
   end

endmodule

// File: rtl/bridge_pwm.sv
module bridge_pwm
   import bpwm_pkg::*;
#(
   parameter int TMR_W = 8,
   parameter int SUB_W = 2,
   parameter int N_OUT = 4,
   localparam int CNT_W   = TMR_W + SUB_W,
   localparam int LSB_LO  = 0,
   localparam int MODE_LO = SUB_W,
   localparam int RUN_LO  = TMR_W - 2,
   localparam int SPARE_W = RUN_LO - (MODE_LO + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [TMR_W-1:0] wr_data,
   output logic [N_OUT-1:0] pwm_out
);

   logic [TMR_W-1:0] per_q;
   logic [TMR_W-1:0] dhi_q;
   logic [SUB_W-1:0] lsb_q;
   steer_e           mode_q;
   steer_e           mode_act_q;
   logic             run_q;
   logic [CNT_W-1:0] cnt;
   logic             boundary;
   logic             level;
   logic [N_OUT-1:0] drive;
   logic [N_OUT-1:0] out_q;

   if (SPARE_W < 0) begin : g_bad_layout
      $error("bridge_pwm: control word too narrow for its fields");
   end

   if (SPARE_W > 0) begin : g_spare
      logic spare_unused;
      assign spare_unused = ^wr_data[RUN_LO-1:MODE_LO+2];
   end

   // software-visible registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q  <= '0;
         dhi_q  <= '0;
         lsb_q  <= '0;
         mode_q <= STEER_SINGLE;
         run_q  <= 1'b0;
      end else if (wr_en) begin
         unique case (wr_addr)
            ADDR_PERIOD: per_q <= wr_data;
            ADDR_DUTY:   dhi_q <= wr_data;
            ADDR_CTRL: begin
               lsb_q  <= wr_data[LSB_LO +: SUB_W];
               mode_q <= steer_e'(wr_data[MODE_LO +: 2]);
               run_q  <= (wr_data[RUN_LO +: 2] == RUN_KEY);
            end
            default: ;
         endcase
      end
   end

   bpwm_timebase #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_timebase (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .per_in   (per_q),
      .cnt      (cnt),
      .boundary (boundary)
   );

   bpwm_duty #(.CNT_W(CNT_W)) u_duty (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (boundary),
      .duty_in ({dhi_q, lsb_q}),
      .cnt     (cnt),
      .level   (level)
   );

   // steering shadow, refreshed with the duty shadow
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode_act_q <= STEER_SINGLE;
      else if (boundary) mode_act_q <= mode_q;
   end

   bpwm_steer #(.N_OUT(N_OUT)) u_steer (
      .mode  (mode_act_q),
      .level (level),
      .drive (drive)
   );

   // registered output stage keeps decode glitches off the pins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     out_q <= '0;
      else if (run_q) out_q <= drive;
      else            out_q <= '0;
   end

   assign pwm_out = out_q;

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> (pwm_out == '0));

   assert_single_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && mode_act_q == STEER_SINGLE) |=> (pwm_out[3:1] == 3'b000));

   assert_half_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && mode_act_q == STEER_HALF) |=>
         (pwm_out[1] == !pwm_out[0]) && (pwm_out[3:2] == 2'b00));

   assert_fwd_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && mode_act_q == STEER_FWD) |=>
         pwm_out[0] && !pwm_out[1] && !pwm_out[2]);

   assert_rev_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && mode_act_q == STEER_REV) |=>
         pwm_out[2] && !pwm_out[0] && !pwm_out[3]);

   assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(mode_act_q));

endmodule

// File: tb/bridge_pwm_tb.sv
module bridge_pwm_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] pwm_out;

   int total = 0;
   int bad = 0;
   bit done = 0;

   bridge_pwm u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .pwm_out (pwm_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(string req, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [7:0] ctrl_word(logic [1:0] key, logic [1:0] mode, int duty);
      return {key, 2'b00, mode, duty[1:0]};
   endfunction

   task automatic cfg(int per, int duty, logic [1:0] mode);
      wr(2'd0, per[7:0]);
      wr(2'd1, duty[9:2]);
      wr(2'd2, ctrl_word(2'b11, mode, duty));
      repeat (3 * (per + 1) * 4 + 4) @(negedge clk);
   endtask

   task automatic measure(int n, output int ca, output int cb, output int cc, output int cd);
      ca = 0; cb = 0; cc = 0; cd = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         ca += int'(pwm_out[0]); cb += int'(pwm_out[1]);
         cc += int'(pwm_out[2]); cd += int'(pwm_out[3]);
      end
   endtask

   task automatic wait_rise(int i);
      logic p;
      p = pwm_out[i];
      for (int g = 0; g < 5000; g++) begin
         @(negedge clk);
         if (!p && pwm_out[i]) return;
         p = pwm_out[i];
      end
   endtask

   task automatic rise_gap(int i, output int n);
      logic p;
      p = pwm_out[i];
      n = 0;
      for (int g = 0; g < 5000; g++) begin
         @(negedge clk);
         n++;
         if (!p && pwm_out[i]) return;
         p = pwm_out[i];
      end
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "outputs in reset", int'(pwm_out), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1", "outputs after reset", int'(pwm_out), 0);
   endtask

   task automatic test_modes();
      int len, h, ca, cb, cc, cd;
      int duties [4] = '{0, 37, 50, 1023};
      len = 25 * 4;
      for (int m = 0; m < 4; m++) begin
         for (int j = 0; j < 4; j++) begin
            cfg(24, duties[j], 2'(m));
            h = (duties[j] < len) ? duties[j] : len;
            measure(len, ca, cb, cc, cd);
            chk("R3", "high count within period bound", (ca <= len) ? 1 : 0, 1);
            case (m)
               0: begin // single, R5 with R4 width
                  chk("R5", "single A", ca, h); chk("R5", "single B", cb, 0);
                  chk("R5", "single C", cc, 0); chk("R4", "single D", cd, 0);
               end
               2: begin // half bridge, R6
                  chk("R6", "half A", ca, h); chk("R6", "half B", cb, len - h);
                  chk("R6", "half C", cc, 0); chk("R6", "half D", cd, 0);
               end
               1: begin // full forward, R7
                  chk("R7", "fwd A", ca, len); chk("R7", "fwd B", cb, 0);
                  chk("R7", "fwd C", cc, 0); chk("R7", "fwd D", cd, h);
               end
               default: begin // full reverse, R8
                  chk("R8", "rev A", ca, 0); chk("R8", "rev B", cb, h);
                  chk("R8", "rev C", cc, len); chk("R8", "rev D", cd, 0);
               end
            endcase
         end
      end
   endtask

   task automatic test_gate();
      int ca, cb, cc, cd;
      cfg(9, 20, 2'b01);
      wr(2'd2, ctrl_word(2'b10, 2'b01, 20));
      @(negedge clk);
      measure(40, ca, cb, cc, cd);
      chk("R2", "key 10 keeps lines low", ca + cb + cc + cd, 0);
      wr(2'd2, ctrl_word(2'b01, 2'b01, 20));
      @(negedge clk);
      measure(40, ca, cb, cc, cd);
      chk("R2", "key 01 keeps lines low", ca + cb + cc + cd, 0);
   endtask

   task automatic test_clear();
      int ca, cb, cc, cd;
      cfg(9, 40, 2'b01);
      wr(2'd2, 8'h00);
      @(negedge clk);
      chk("R2", "cleared control quiets lines", int'(pwm_out), 0);
      measure(40, ca, cb, cc, cd);
      chk("R2", "lines stay low after clear", ca + cb + cc + cd, 0);
   endtask

   task automatic test_duty_latch();
      int n;
      cfg(9, 20, 2'b00);
      wait_rise(0);
      wr(2'd1, 8'd2);            // new duty 8, written mid-pulse
      n = 2;
      for (int g = 0; g < 100; g++) begin
         @(negedge clk);
         if (pwm_out[0]) n++; else break;
      end
      chk("R9", "pulse in progress keeps old width", n, 20);
      wait_rise(0);
      n = 1;
      for (int g = 0; g < 100; g++) begin
         @(negedge clk);
         if (pwm_out[0]) n++; else break;
      end
      chk("R9", "next pulse uses new width", n, 8);
   endtask

   task automatic test_period_change();
      int n;
      cfg(9, 12, 2'b00);
      wait_rise(0);
      wr(2'd0, 8'd3);            // one clock of the gap used by the write
      rise_gap(0, n);
      chk("R10", "current period keeps old length", n + 1, 40);
      rise_gap(0, n);
      chk("R3", "new period length (3+1)*4", n, 16);
      cfg(0, 2, 2'b00);
      wait_rise(0);
      rise_gap(0, n);
      chk("R3", "shortest period length", n, 4);
   endtask

   task automatic test_mode_change();
      int ca, cb, cc, cd, early;
      cfg(9, 20, 2'b00);
      wait_rise(0);
      wr(2'd2, ctrl_word(2'b11, 2'b10, 20));
      early = 0;
      for (int g = 0; g < 30; g++) begin
         @(negedge clk);
         early += int'(pwm_out[1]);
      end
      chk("R10", "B stays low until boundary", early, 0);
      repeat (120) @(negedge clk);
      measure(40, ca, cb, cc, cd);
      chk("R10", "half mode active after boundary A", ca, 20);
      chk("R10", "half mode active after boundary B", cb, 20);
   endtask

   task automatic test_bad_addr();
      int ca, cb, cc, cd;
      cfg(9, 20, 2'b00);
      wr(2'd3, 8'h00);
      repeat (90) @(negedge clk);
      measure(40, ca, cb, cc, cd);
      chk("R11", "address 3 leaves duty", ca, 20);
      chk("R11", "address 3 leaves control", cb + cc + cd, 0);
   endtask

   initial begin
      test_reset();
      test_modes();
      test_gate();
      test_clear();
      test_duty_latch();
      test_period_change();
      test_mode_change();
      test_bad_addr();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule